// File: doc/BRIEF.md
# Asynchronous NOR Page-Read Timing Engine

This block runs asynchronous reads against a parallel NOR-style memory by counting functional-clock cycles. A host starts an access through a simple request port. A single read returns one word. A page read returns two to four consecutive words from the same four-word page. The engine drives chip select, the address-valid strobe, output enable, the byte enables and the address bus. It captures the returned data on internal clock edges at programmed offsets and hands each word back with a one-cycle valid strobe.

Every timing field is a cycle count. A granularity bit doubles all of them at once. The delay to the first capture and the spacing between later page captures are counted separately. The engine copies the timing fields at the moment it accepts a request, so the host may change them while an access runs. It refuses new requests until the access and the programmed idle gap have ended.

Top module: `nor_page_rd_engine`

## Requirements
- R1: After reset, all memory strobes (`mem_cs_n`, `mem_adv_n`, `mem_oe_n`, both bits of `mem_be_n`) are high, `mem_addr` is zero, `req_ready` is high and `rsp_valid` is low.
- R2: Cycle k=0 is the clock cycle that follows the edge accepting a request. Let m = 2 when `cfg_gran`=1 and m = 1 otherwise. For a single read (`req_page`=0), `rsp_valid` is high in exactly one cycle, k = F, where F = max(`cfg_acc`·m, `cfg_oe_on`·m + 1). In that cycle `rsp_last`=1, and `rsp_data` holds the memory data present during cycle F−1. `req_len` has no effect in this mode.
- R3: For a page read (`req_page`=1), N = `req_len`+1 words are returned. Word i appears at k = F + i·P, where P = max(`cfg_page_acc`·m, 1). `rsp_last` is high only with the final word.
- R4: `cfg_gran`=1 doubles every timing field: the access time, the page time, the address-valid on/off points, the output-enable on point, the output-enable hold and the idle gap.
- R5: While chip select is low, `mem_addr` equals {base[AW-1:2], (base[1:0]+i) mod 4}, where base is `req_addr` and i is the number of words already captured (it stays at the last index after the final capture). The address moves to the next word on the edge that captures the current one. `mem_addr` is zero whenever chip select is high.
- R6: `mem_cs_n` and both `mem_be_n` bits are low for cycles 0 ≤ k < L + H and high otherwise. L = F + (N−1)·P is the cycle of the final response, and H = `cfg_oe_off`·m.
- R7: `mem_adv_n` is low exactly for cycles k with `cfg_adv_on`·m ≤ k < `cfg_adv_off`·m and k < L.
- R8: `mem_oe_n` is low exactly for cycles `cfg_oe_on`·m ≤ k < L + H. Every capture therefore happens on an edge that closes a cycle in which output enable was low, even when `cfg_acc` is zero or smaller than the output-enable on point.
- R9: `req_ready` is low from k=0 until cycle L + H + G, where G = `cfg_gap`·m, and is high again from that cycle on. During the G gap cycles chip select is high and the address is zero.
- R10: Timing fields and `cfg_gran` are sampled on the accepting edge. Changing them during an access has no effect on any strobe, address or response timing of that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host requests an access |
| req_ready | output | 1 | Engine can accept a request |
| req_page | input | 1 | 1 = page read, 0 = single read |
| req_len | input | 2 | Page words minus one (page mode only) |
| req_addr | input | AW | Word address of the first word |
| cfg_gran | input | 1 | Granularity: 1 doubles all timing fields |
| cfg_acc | input | TW | Cycles from access start to first capture |
| cfg_page_acc | input | TW | Cycles between successive page captures |
| cfg_adv_on | input | TW | Address-valid assertion point |
| cfg_adv_off | input | TW | Address-valid deassertion point |
| cfg_oe_on | input | TW | Output-enable assertion point |
| cfg_oe_off | input | TW | Output-enable hold after final capture |
| cfg_gap | input | TW | Idle cycles required between accesses |
| rsp_valid | output | 1 | One-cycle strobe per returned word |
| rsp_data | output | DW | Captured word |
| rsp_last | output | 1 | Marks the final word of the access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid / latch enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_addr | output | AW | Memory word address |
| mem_data | input | DW | Data returned by the memory |

## Verification
The bench uses the default parameters: 16-bit address and data, 4-bit timing fields and the granularity option enabled. With 4-bit fields every clamp can be reached: an access time of zero, an access time below the output-enable point and a page time of zero. With granularity enabled, the doubled windows and the latching of the granularity bit can be checked against the cycle-by-cycle reference. The memory model returns a marker value whenever output enable is high, so a capture taken outside the output-enable window shows up as wrong data.

// File: rtl/nor_rd_pkg.sv
// Shared definitions for the NOR page-read engine.
// Assumes: a single functional clock; all timing is counted in that clock.
package nor_rd_pkg;
    // Access phases: idle, reading, output-enable hold, inter-access gap
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACT  = 2'd1,
        ST_TAIL = 2'd2,
        ST_GAP  = 2'd3
    } nor_st_e;

    localparam int unsigned PAGE_WORDS = 4;
endpackage

// File: rtl/nor_rd_scale.sv
// Scales one programmed timing field by the granularity factor (setting + 1).
// Assumes: the granularity setting is a single bit, so the factor is 1 or 2.
module nor_rd_scale #(
    parameter int TW      = 4,
    parameter bit GRAN_EN = 1'b1
) (
    input  logic [TW-1:0] fld,
    input  logic          gran,
    output logic [TW:0]   val
);
    generate
        if (GRAN_EN) begin : g_gran
            // Double the field when granularity is set
            assign val = gran ? {fld, 1'b0} : {1'b0, fld};
        end else begin : g_plain
            logic unused_gran;
            assign unused_gran = gran;
            // Granularity disabled: pass the field through
            assign val = {1'b0, fld};
        end
    endgenerate
endmodule

// File: rtl/nor_rd_seq.sv
// Access sequencer: accepts requests, latches scaled timing, counts cycles,
// captures page words and walks the phases act -> hold -> gap -> idle.
// Assumes: scaled timing inputs are only meaningful on the accepting edge.
module nor_rd_seq
    import nor_rd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_page,
    input  logic [1:0]    req_len,
    input  logic [AW-1:0] req_addr,
    input  logic [TW:0]   acc_s,
    input  logic [TW:0]   pg_s,
    input  logic [TW:0]   adv_on_s,
    input  logic [TW:0]   adv_off_s,
    input  logic [TW:0]   oe_on_s,
    input  logic [TW:0]   oe_off_s,
    input  logic [TW:0]   gap_s,
    input  logic [DW-1:0] mem_data,
    output nor_st_e       st,
    output logic [TW+3:0] tcnt,
    output logic [TW:0]   adv_on_l,
    output logic [TW:0]   adv_off_l,
    output logic [TW:0]   oe_on_l,
    output logic [AW-1:0] cur_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_last
);
    localparam int SW = TW + 1;
    localparam int CW = TW + 4;

    logic [CW-1:0] cap_cnt;
    logic [SW-1:0] ph_cnt;
    logic [SW-1:0] pg_l, tail_l, gap_l;
    logic [1:0]    widx, wlast;
    logic [AW-1:0] base;
    logic [CW-1:0] acc_w, oe1_w, first_w;
    logic [SW-1:0] pg_eff;
    logic [1:0]    lo_bits;

    // First capture point: never before the cycle after output enable asserts
    always_comb begin
        acc_w   = CW'(acc_s);
        oe1_w   = CW'(oe_on_s) + CW'(1);
        first_w = (acc_w >= oe1_w) ? acc_w : oe1_w;
        pg_eff  = (pg_s == '0) ? SW'(1) : pg_s;
    end

    // Current word address: wraps within the four-word page
    always_comb begin
        lo_bits  = base[1:0] + widx;
        cur_addr = {base[AW-1:2], lo_bits};
    end

    assign req_ready = (st == ST_IDLE);

    // Phase machine, cycle counter and data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            tcnt      <= '0;
            cap_cnt   <= '0;
            ph_cnt    <= '0;
            pg_l      <= '0;
            tail_l    <= '0;
            gap_l     <= '0;
            adv_on_l  <= '0;
            adv_off_l <= '0;
            oe_on_l   <= '0;
            widx      <= '0;
            wlast     <= '0;
            base      <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_last  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_last  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        st        <= ST_ACT;
                        tcnt      <= '0;
                        cap_cnt   <= first_w;
                        pg_l      <= pg_eff;
                        tail_l    <= oe_off_s;
                        gap_l     <= gap_s;
                        adv_on_l  <= adv_on_s;
                        adv_off_l <= adv_off_s;
                        oe_on_l   <= oe_on_s;
                        widx      <= '0;
                        wlast     <= req_page ? req_len : 2'd0;
                        base      <= req_addr;
                    end
                end
                ST_ACT: begin
                    if (tcnt != '1) tcnt <= tcnt + CW'(1);
                    if (cap_cnt == CW'(1)) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= mem_data;
                        if (widx == wlast) begin
                            rsp_last <= 1'b1;
                            if (tail_l != '0) begin
                                st     <= ST_TAIL;
                                ph_cnt <= tail_l;
                            end else if (gap_l != '0) begin
                                st     <= ST_GAP;
                                ph_cnt <= gap_l;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            widx    <= widx + 2'd1;
                            cap_cnt <= CW'(pg_l);
                        end
                    end else begin
                        cap_cnt <= cap_cnt - CW'(1);
                    end
                end
                ST_TAIL: begin
                    if (tcnt != '1) tcnt <= tcnt + CW'(1);
                    if (ph_cnt == SW'(1)) begin
                        if (gap_l != '0) begin
                            st     <= ST_GAP;
                            ph_cnt <= gap_l;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else begin
                        ph_cnt <= ph_cnt - SW'(1);
                    end
                end
                ST_GAP: begin
                    if (ph_cnt == SW'(1)) st <= ST_IDLE;
                    else                  ph_cnt <= ph_cnt - SW'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nor_rd_strobe.sv
// Derives the active-low memory strobes and the address bus from the phase
// and the cycle counter. Assumes latched offsets stay stable for the access.
module nor_rd_strobe
    import nor_rd_pkg::*;
#(
    parameter int AW = 16,
    parameter int TW = 4
) (
    input  nor_st_e       st,
    input  logic [TW+3:0] tcnt,
    input  logic [TW:0]   adv_on_l,
    input  logic [TW:0]   adv_off_l,
    input  logic [TW:0]   oe_on_l,
    input  logic [AW-1:0] cur_addr,
    output logic          mem_cs_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic [1:0]    mem_be_n,
    output logic [AW-1:0] mem_addr
);
    localparam int CW = TW + 4;

    logic sel, in_act;

    // Strobe windows relative to the start of the access
    always_comb begin
        in_act    = (st == ST_ACT);
        sel       = in_act || (st == ST_TAIL);
        mem_cs_n  = !sel;
        mem_be_n  = {2{!sel}};
        mem_adv_n = !(in_act && (tcnt >= CW'(adv_on_l)) && (tcnt < CW'(adv_off_l)));
        mem_oe_n  = !(sel && (tcnt >= CW'(oe_on_l)));
        mem_addr  = sel ? cur_addr : '0;
    end
endmodule

// File: rtl/nor_page_rd_engine.sv
// Top level: scales the timing fields, sequences the access and drives the
// memory strobes. Assumes mem_data is stable around each capture edge.
module nor_page_rd_engine
    import nor_rd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int TW      = 4,
    parameter bit GRAN_EN = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_page,
    input  logic [1:0]    req_len,
    input  logic [AW-1:0] req_addr,
    input  logic          cfg_gran,
    input  logic [TW-1:0] cfg_acc,
    input  logic [TW-1:0] cfg_page_acc,
    input  logic [TW-1:0] cfg_adv_on,
    input  logic [TW-1:0] cfg_adv_off,
    input  logic [TW-1:0] cfg_oe_on,
    input  logic [TW-1:0] cfg_oe_off,
    input  logic [TW-1:0] cfg_gap,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_last,
    output logic          mem_cs_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic [1:0]    mem_be_n,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_data
);
    localparam int NF = 7;

    logic [TW-1:0] fld_a [NF];
    logic [TW:0]   sc_a  [NF];

    nor_st_e       st;
    logic [TW+3:0] tcnt;
    logic [TW:0]   adv_on_l, adv_off_l, oe_on_l;
    logic [AW-1:0] cur_addr;

    // Gather the raw fields in a fixed order for scaling
    always_comb begin
        fld_a[0] = cfg_acc;
        fld_a[1] = cfg_page_acc;
        fld_a[2] = cfg_adv_on;
        fld_a[3] = cfg_adv_off;
        fld_a[4] = cfg_oe_on;
        fld_a[5] = cfg_oe_off;
        fld_a[6] = cfg_gap;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_scale
            nor_rd_scale #(.TW(TW), .GRAN_EN(GRAN_EN)) u_scale (
                .fld  (fld_a[gi]),
                .gran (cfg_gran),
                .val  (sc_a[gi])
            );
        end
    endgenerate

    nor_rd_seq #(.AW(AW), .DW(DW), .TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_page  (req_page),
        .req_len   (req_len),
        .req_addr  (req_addr),
        .acc_s     (sc_a[0]),
        .pg_s      (sc_a[1]),
        .adv_on_s  (sc_a[2]),
        .adv_off_s (sc_a[3]),
        .oe_on_s   (sc_a[4]),
        .oe_off_s  (sc_a[5]),
        .gap_s     (sc_a[6]),
        .mem_data  (mem_data),
        .st        (st),
        .tcnt      (tcnt),
        .adv_on_l  (adv_on_l),
        .adv_off_l (adv_off_l),
        .oe_on_l   (oe_on_l),
        .cur_addr  (cur_addr),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .rsp_last  (rsp_last)
    );

    nor_rd_strobe #(.AW(AW), .TW(TW)) u_strobe (
        .st        (st),
        .tcnt      (tcnt),
        .adv_on_l  (adv_on_l),
        .adv_off_l (adv_off_l),
        .oe_on_l   (oe_on_l),
        .cur_addr  (cur_addr),
        .mem_cs_n  (mem_cs_n),
        .mem_adv_n (mem_adv_n),
        .mem_oe_n  (mem_oe_n),
        .mem_be_n  (mem_be_n),
        .mem_addr  (mem_addr)
    );
endmodule

// File: rtl/nor_rd_chk.sv
// Protocol checker for the NOR page-read engine, bound to the top module.
// Assumes: synchronous active-low reset; observes top-level ports only.
module nor_rd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       rsp_last,
    input logic       mem_cs_n,
    input logic       mem_adv_n,
    input logic       mem_oe_n,
    input logic [1:0] mem_be_n
);
    logic [2:0] rsp_seen;

    // Count responses returned within the current access
    always_ff @(posedge clk) begin
        if (!rst_n)                      rsp_seen <= '0;
        else if (req_valid && req_ready) rsp_seen <= '0;
        else if (rsp_valid && rsp_seen != 3'd7) rsp_seen <= rsp_seen + 3'd1;
    end

    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_cs_n);                          // R8
    AST_ADV_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> !mem_cs_n);                         // R7
    AST_BE_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_be_n == {2{mem_cs_n}});                        // R6
    AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);                         // R9
    AST_CAPTURE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(!mem_oe_n));            // R8
    AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_seen < 3'd4);                    // R3
    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |=> !rsp_valid);           // R3
endmodule

bind nor_page_rd_engine nor_rd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_last  (rsp_last),
    .mem_cs_n  (mem_cs_n),
    .mem_adv_n (mem_adv_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n)
);

// File: tb/tb_nor_page_rd_engine.sv
// Directed bench: one task per scenario, cycle-exact reference per access.
`timescale 1ns/1ps
module tb_nor_page_rd_engine;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_page;
    logic [1:0]    req_len;
    logic [AW-1:0] req_addr;
    logic          cfg_gran;
    logic [TW-1:0] cfg_acc, cfg_page_acc, cfg_adv_on, cfg_adv_off;
    logic [TW-1:0] cfg_oe_on, cfg_oe_off, cfg_gap;
    logic          rsp_valid, rsp_last;
    logic [DW-1:0] rsp_data;
    logic          mem_cs_n, mem_adv_n, mem_oe_n;
    logic [1:0]    mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    // Memory model: marker value whenever output enable is high
    assign mem_data = mem_oe_n ? 16'hDEAD : (mem_addr ^ 16'h5A3C);

    nor_page_rd_engine #(.AW(AW), .DW(DW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page),
        .req_len(req_len), .req_addr(req_addr), .cfg_gran(cfg_gran),
        .cfg_acc(cfg_acc), .cfg_page_acc(cfg_page_acc),
        .cfg_adv_on(cfg_adv_on), .cfg_adv_off(cfg_adv_off),
        .cfg_oe_on(cfg_oe_on), .cfg_oe_off(cfg_oe_off), .cfg_gap(cfg_gap),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .mem_cs_n(mem_cs_n), .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] b, input int i);
        logic [1:0] lo;
        lo = b[1:0] + 2'(i);
        return {b[AW-1:2], lo};
    endfunction

    // One access with a full cycle-by-cycle reference
    task automatic run_read(input string tag, input logic page, input logic [1:0] len,
                            input logic [AW-1:0] base, input int acc, input int pg,
                            input int aon, input int aoff, input int oon, input int ooff,
                            input int gap, input logic g, input bit scramble);
        int m, f, p, n, last_k, h, gs, kend, widx;
        logic [AW-1:0] ea;
        m  = g ? 2 : 1;
        f  = (acc * m >= oon * m + 1) ? acc * m : oon * m + 1;
        p  = (pg * m == 0) ? 1 : pg * m;
        n  = page ? int'(len) + 1 : 1;
        last_k = f + (n - 1) * p;
        h  = ooff * m;
        gs = gap * m;
        kend = last_k + h + gs;
        @(negedge clk);
        cfg_gran = g; cfg_acc = TW'(acc); cfg_page_acc = TW'(pg);
        cfg_adv_on = TW'(aon); cfg_adv_off = TW'(aoff);
        cfg_oe_on = TW'(oon); cfg_oe_off = TW'(ooff); cfg_gap = TW'(gap);
        req_page = page; req_len = len; req_addr = base; req_valid = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= kend; k++) begin
            @(negedge clk);
            if (k == 0) begin
                req_valid = 1'b0;
                if (scramble) begin
                    cfg_gran = ~g; cfg_acc = '1; cfg_page_acc = '1; cfg_adv_on = '0;
                    cfg_adv_off = '1; cfg_oe_on = '0; cfg_oe_off = '1; cfg_gap = '1;
                    req_addr = ~base;
                end
            end
            widx = 0;
            for (int i = 1; i < n; i++) if (k >= f + (i - 1) * p) widx = i;
            check(mem_cs_n == !(k < last_k + h), "R6", $sformatf("%s cs_n k=%0d", tag, k),
                  32'(mem_cs_n), 32'(!(k < last_k + h)));
            check(mem_be_n == {2{mem_cs_n}} && mem_cs_n == !(k < last_k + h), "R6",
                  $sformatf("%s be_n k=%0d", tag, k), 32'(mem_be_n), 32'({2{!(k < last_k + h)}}));
            check(mem_oe_n == !(k >= oon * m && k < last_k + h), "R8",
                  $sformatf("%s oe_n k=%0d", tag, k), 32'(mem_oe_n),
                  32'(!(k >= oon * m && k < last_k + h)));
            check(mem_adv_n == !(k >= aon * m && k < aoff * m && k < last_k), "R7",
                  $sformatf("%s adv_n k=%0d", tag, k), 32'(mem_adv_n),
                  32'(!(k >= aon * m && k < aoff * m && k < last_k)));
            check(req_ready == (k >= kend), "R9", $sformatf("%s ready k=%0d", tag, k),
                  32'(req_ready), 32'(k >= kend));
            ea = (k < last_k + h) ? word_addr(base, widx) : '0;
            check(mem_addr == ea, "R5", $sformatf("%s addr k=%0d", tag, k),
                  32'(mem_addr), 32'(ea));
            begin
                bit exp_rv;
                int wi;
                exp_rv = 1'b0; wi = 0;
                for (int i = 0; i < n; i++) if (k == f + i * p) begin exp_rv = 1'b1; wi = i; end
                check(rsp_valid == exp_rv, tag, $sformatf("rsp_valid k=%0d", k),
                      32'(rsp_valid), 32'(exp_rv));
                if (exp_rv && rsp_valid) begin
                    check(rsp_data == (word_addr(base, wi) ^ 16'h5A3C), tag,
                          $sformatf("data word %0d", wi), 32'(rsp_data),
                          32'(word_addr(base, wi) ^ 16'h5A3C));
                    check(rsp_last == (wi == n - 1), tag, $sformatf("last word %0d", wi),
                          32'(rsp_last), 32'(wi == n - 1));
                end
            end
        end
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        check({mem_cs_n, mem_adv_n, mem_oe_n, mem_be_n} == 5'h1F, "R1", "strobes after reset",
              32'({mem_cs_n, mem_adv_n, mem_oe_n, mem_be_n}), 32'h1F);
        check(mem_addr == '0, "R1", "address after reset", 32'(mem_addr), 32'd0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    endtask

    // Single read; req_len=3 must be ignored (R2)
    task automatic t_single;
        run_read("R2", 1'b0, 2'd3, 16'h0102, 5, 2, 0, 2, 1, 1, 2, 1'b0, 1'b0);
    endtask

    // Access time zero clamped behind output enable (R8)
    task automatic t_acc_zero;
        run_read("R8", 1'b0, 2'd0, 16'h7777, 0, 1, 1, 3, 3, 0, 0, 1'b0, 1'b0);
    endtask

    // Access time below output-enable point (R8)
    task automatic t_acc_early;
        run_read("R8", 1'b1, 2'd1, 16'h4440, 2, 3, 0, 1, 5, 2, 1, 1'b0, 1'b0);
    endtask

    // Four-word page, separate first and page spacing (R3)
    task automatic t_page4;
        run_read("R3", 1'b1, 2'd3, 16'h1230, 6, 2, 1, 4, 2, 1, 3, 1'b0, 1'b0);
    endtask

    // Granularity doubles every field (R4)
    task automatic t_gran;
        run_read("R4", 1'b1, 2'd2, 16'hA5A4, 3, 2, 1, 3, 1, 2, 3, 1'b1, 1'b0);
    endtask

    // Page wraps within four words; page time zero clamped to 1 (R5, R3)
    task automatic t_wrap;
        run_read("R5", 1'b1, 2'd2, 16'h00F2, 4, 0, 0, 2, 2, 1, 1, 1'b0, 1'b0);
    endtask

    // Fields changed right after acceptance have no effect (R10)
    task automatic t_latch;
        run_read("R10", 1'b1, 2'd3, 16'h3C3D, 4, 2, 1, 3, 2, 2, 2, 1'b0, 1'b1);
    endtask

    // Back-to-back accesses with no gap and no hold (R9)
    task automatic t_b2b;
        run_read("R9", 1'b0, 2'd0, 16'h0010, 2, 1, 0, 1, 0, 0, 0, 1'b0, 1'b0);
        run_read("R9", 1'b1, 2'd1, 16'h0013, 1, 1, 0, 1, 0, 0, 0, 1'b1, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_page = 1'b0; req_len = '0; req_addr = '0;
        cfg_gran = 1'b0; cfg_acc = '0; cfg_page_acc = '0; cfg_adv_on = '0;
        cfg_adv_off = '0; cfg_oe_on = '0; cfg_oe_off = '0; cfg_gap = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_acc_zero();
        t_acc_early();
        t_page4();
        t_gran();
        t_wrap();
        t_latch();
        t_b2b();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule